// File: doc/BRIEF.md
# Fault-First Vector Element Loader

This block carries out a vector load one element at a time. A start pulse supplies a base address, an element stride and a requested element count. The block then walks the element addresses in order and issues each one to a memory port. It waits for each response before it issues the next. Every successful response is written into a register write port at the element's index.

A fault on the very first element cannot be absorbed, so it raises a trap. A fault on any later element does not trap. Instead it ends the operation early, and the reported length is the number of elements that completed before the fault. Software reads that length to learn how much of the vector is valid.

The memory request and response sides are valid/ready streams. A request holds its address steady until `mreq_ready` accepts it. A response is consumed only in a cycle where `mrsp_valid` and `mrsp_ready` are both high. The block raises `mrsp_ready` only while it waits for the response to its single outstanding request. The register write port cannot stall the block.

Top module: `ffld_seq`

## Requirements
- R1: Element i is requested at address base + i*stride (modulo 2^AW), in increasing order of i, and no new request is issued until the response to the previous one has been taken.
- R2: Each element whose response carries no fault is written once, with `rf_we` high for one cycle, `rf_idx` = i and `rf_wdata` = the response data.
- R3: A fault on element 0 pulses `trap` for one cycle, sets `vlen` to 0, writes nothing and does not pulse `done`.
- R4: A fault on element k (k >= 1) ends the operation: `done` pulses and `vlen` = k. No request is issued for any element after k.
- R5: Data from a faulting response is never written (`rf_we` is low in that cycle).
- R6: A requested count of 0 pulses `done` in the cycle after the start. `vlen` is then 0 and no memory request is issued.
- R7: When all elements succeed, `done` pulses in the cycle after the last response is taken, and `vlen` equals the requested count.
- R8: `done` and `trap` are single-cycle pulses and never high together. `vlen` changes only in the cycle either of them is high, and holds its value otherwise.
- R9: While `mreq_valid` is high and `mreq_ready` is low, the request stays valid with an unchanged address.
- R10: A start pulse that arrives while an operation is in progress is ignored, and the running operation completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| start_base | input | AW | Address of element 0 |
| start_stride | input | AW | Byte distance between elements |
| start_count | input | CW | Requested element count |
| mreq_valid | output | 1 | Request valid |
| mreq_ready | input | 1 | Memory accepts request |
| mreq_addr | output | AW | Request address |
| mrsp_valid | input | 1 | Response valid |
| mrsp_ready | output | 1 | Block accepts response |
| mrsp_data | input | DW | Response data |
| mrsp_fault | input | 1 | Response reports a fault |
| rf_we | output | 1 | Register write enable |
| rf_idx | output | CW | Element index being written |
| rf_wdata | output | DW | Data written |
| done | output | 1 | Operation finished (pulse) |
| trap | output | 1 | First-element fault (pulse) |
| vlen | output | CW | Elements actually loaded |

## Verification
The element index and the address register advance together. If either drifts, the next write goes to the wrong index or carries data from the wrong address, and this shows on the very next `rf_we` after the fault in the state. A wrong count or fault decision shows as early or late completion, or as `done` where `trap` was due, in the cycle after the deciding response. The bench stalls both handshakes in varying patterns so that hold-and-wait errors are exposed at the first stalled request.

// File: rtl/ffld_pkg.sv
package ffld_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } ffld_state_e;
endpackage

// File: rtl/ffld_addr_gen.sv
module ffld_addr_gen #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] stride,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] stride_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr     <= '0;
      stride_q <= '0;
    end else if (load) begin
      addr     <= base;
      stride_q <= stride;
    end else if (step) begin
      addr <= addr + stride_q;
    end
  end
endmodule

// File: rtl/ffld_ctrl.sv
module ffld_ctrl
  import ffld_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] start_count,
  output logic          mreq_valid,
  input  logic          mreq_ready,
  input  logic          mrsp_valid,
  output logic          mrsp_ready,
  input  logic          mrsp_fault,
  output logic          load,
  output logic          step,
  output logic          rf_we,
  output logic [CW-1:0] rf_idx,
  output logic          done,
  output logic          trap,
  output logic [CW-1:0] vlen
);
  ffld_state_e   state;
  logic [CW-1:0] idx_q;
  logic [CW-1:0] cnt_q;
  logic          rsp_take;
  logic          last_elem;

  assign mreq_valid = (state == ST_REQ);
  assign mrsp_ready = (state == ST_WAIT);
  assign rsp_take   = mrsp_ready && mrsp_valid;
  assign last_elem  = (CW'(idx_q + 1'b1) == cnt_q);
  assign load       = (state == ST_IDLE) && start;
  assign step       = rsp_take && !mrsp_fault && !last_elem;
  assign rf_we      = rsp_take && !mrsp_fault;
  assign rf_idx     = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx_q <= '0;
      cnt_q <= '0;
      done  <= 1'b0;
      trap  <= 1'b0;
      vlen  <= '0;
    end else begin
      done <= 1'b0;
      trap <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          idx_q <= '0;
          cnt_q <= start_count;
          if (start_count == '0) begin
            done <= 1'b1;
            vlen <= '0;
          end else begin
            state <= ST_REQ;
          end
        end
        ST_REQ: if (mreq_ready) state <= ST_WAIT;
        ST_WAIT: if (mrsp_valid) begin
          if (mrsp_fault) begin
            state <= ST_IDLE;
            vlen  <= idx_q;
            if (idx_q == '0) trap <= 1'b1;
            else             done <= 1'b1;
          end else if (last_elem) begin
            state <= ST_IDLE;
            done  <= 1'b1;
            vlen  <= cnt_q;
          end else begin
            idx_q <= idx_q + 1'b1;
            state <= ST_REQ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_trap_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> !trap);
  assert_vlen_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !trap) |-> $stable(vlen));
  assert_trap_not_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> (!done && vlen == '0));
  assert_len_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (vlen <= cnt_q));
endmodule

// File: rtl/ffld_seq.sv
module ffld_seq #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_base,
  input  logic [AW-1:0] start_stride,
  input  logic [CW-1:0] start_count,
  output logic          mreq_valid,
  input  logic          mreq_ready,
  output logic [AW-1:0] mreq_addr,
  input  logic          mrsp_valid,
  output logic          mrsp_ready,
  input  logic [DW-1:0] mrsp_data,
  input  logic          mrsp_fault,
  output logic          rf_we,
  output logic [CW-1:0] rf_idx,
  output logic [DW-1:0] rf_wdata,
  output logic          done,
  output logic          trap,
  output logic [CW-1:0] vlen
);
  logic load, step;

  ffld_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .start_count(start_count),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready),
    .mrsp_valid(mrsp_valid), .mrsp_ready(mrsp_ready), .mrsp_fault(mrsp_fault),
    .load(load), .step(step), .rf_we(rf_we), .rf_idx(rf_idx),
    .done(done), .trap(trap), .vlen(vlen)
  );

  ffld_addr_gen #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .base(start_base), .stride(start_stride), .addr(mreq_addr)
  );

  assign rf_wdata = mrsp_data;

  assert_one_outstanding_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && mreq_ready) |=> !mreq_valid);
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_addr)));
  assert_no_fault_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (!mrsp_fault && mrsp_valid));
  assert_no_req_when_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mrsp_ready |-> !mreq_valid);
endmodule

// File: tb/ffld_seq_bench.sv
module ffld_seq_bench;
  localparam int AW = 32, DW = 32, CW = 8;
  localparam logic [DW-1:0] KEY = 32'h5A5A_0000;

  typedef struct packed {
    logic [1:0]    kind;   // 0 write, 1 done, 2 trap
    logic [CW-1:0] idx;
    logic [DW-1:0] data;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic start = 0;
  logic [AW-1:0] start_base = '0, start_stride = '0;
  logic [CW-1:0] start_count = '0;
  logic mreq_valid, mreq_ready, mrsp_valid, mrsp_ready, mrsp_fault;
  logic [AW-1:0] mreq_addr;
  logic [DW-1:0] mrsp_data, rf_wdata;
  logic rf_we, done, trap;
  logic [CW-1:0] rf_idx, vlen;

  always #10 clk = ~clk;

  ffld_seq #(.AW(AW), .DW(DW), .CW(CW)) u_ffld_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_base(start_base),
    .start_stride(start_stride), .start_count(start_count),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_addr(mreq_addr),
    .mrsp_valid(mrsp_valid), .mrsp_ready(mrsp_ready), .mrsp_data(mrsp_data),
    .mrsp_fault(mrsp_fault), .rf_we(rf_we), .rf_idx(rf_idx), .rf_wdata(rf_wdata),
    .done(done), .trap(trap), .vlen(vlen)
  );

  // memory model with varying stalls
  logic [7:0]    cyc = '0;
  logic          pend = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic          fault_en = 1'b0;
  logic [AW-1:0] fault_addr = '0;
  int            nreq = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1'b1;
    if (mreq_valid && mreq_ready) begin
      pend  <= 1'b1;
      paddr <= mreq_addr;
      nreq  <= nreq + 1;
    end else if (mrsp_valid && mrsp_ready) begin
      pend <= 1'b0;
    end
  end
  assign mreq_ready = cyc[0] | cyc[2];
  assign mrsp_valid = pend & (cyc[1] | ~cyc[0]);
  assign mrsp_data  = paddr ^ KEY;
  assign mrsp_fault = fault_en && (paddr == fault_addr);

  int    checks = 0, fails = 0, ends = 0;
  item_t sb[$];
  logic  prev_done = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) if (rst_n) begin
    if (done && prev_done) chk(0, "R8 done pulse", 2, 1);
    prev_done = done;
    if (done && trap) chk(0, "R8 done with trap", 1, 0);
    if (rf_we || done || trap) begin
      if (sb.size() == 0) begin
        chk(0, "R4/R5 unexpected event", {rf_we, done, trap}, 0);
      end else begin
        item_t e;
        e = sb.pop_front();
        if (rf_we) begin
          chk(e.kind == 2'd0, "R2/R5 write kind", 0, e.kind);
          chk(rf_idx == e.idx, "R2 rf_idx", rf_idx, e.idx);
          chk(rf_wdata == e.data, "R1/R2 rf_wdata", rf_wdata, e.data);
        end else if (done) begin
          chk(e.kind == 2'd1, "R4/R6/R7 done kind", 1, e.kind);
          chk(vlen == e.idx, "R4/R6/R7 vlen", vlen, e.idx);
          ends++;
        end else begin
          chk(e.kind == 2'd2, "R3 trap kind", 2, e.kind);
          chk(vlen == '0, "R3 vlen", vlen, 0);
          ends++;
        end
      end
    end
  end

  // driver
  task automatic run_op(input logic [AW-1:0] base, input logic [AW-1:0] stride,
                        input int count, input int fidx, input bit poke);
    int lim, e0, n0;
    item_t it;
    lim = (fidx >= 0 && fidx < count) ? fidx : count;
    for (int i = 0; i < lim; i++) begin
      it.kind = 2'd0; it.idx = CW'(i); it.data = (base + AW'(i) * stride) ^ KEY;
      sb.push_back(it);
    end
    it.kind = (fidx == 0 && count > 0) ? 2'd2 : 2'd1;
    it.idx = CW'(lim); it.data = '0;
    sb.push_back(it);
    fault_en   = (fidx >= 0);
    fault_addr = base + AW'(fidx) * stride;
    e0 = ends; n0 = nreq;
    @(negedge clk);
    start = 1; start_base = base; start_stride = stride; start_count = CW'(count);
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1; start_base = 32'hDEAD_0000; start_stride = 32'h40; start_count = 8'd2;
      @(negedge clk);
      start = 0;
    end
    while (ends == e0) @(negedge clk);
    if (count == 0) chk(nreq == n0, "R6 no requests", nreq - n0, 0);
    else chk(nreq - n0 == lim + ((fidx >= 0 && fidx < count) ? 1 : 0),
             "R1/R4 request count", nreq - n0, lim + 1);
    repeat (4) @(negedge clk);
    chk(vlen == CW'(lim), "R8 vlen held", vlen, lim);
    chk(sb.size() == 0, "R2 scoreboard drained", sb.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !trap && !mreq_valid && !rf_we && vlen == '0, "reset state",
        {done, trap, mreq_valid, rf_we}, 0);
    rst_n = 1;
    run_op(32'h1000, 32'h4, 5, -1, 0);          // R7 full
    run_op(32'h2000, 32'h8, 0, -1, 0);          // R6 zero count
    run_op(32'h3000, 32'h4, 6, 0, 0);           // R3 first fault
    run_op(32'h4000, 32'h10, 8, 3, 0);          // R4 mid fault
    run_op(32'h5000, 32'h4, 4, 3, 0);           // R4 last-element fault
    run_op(32'h6000, 32'hFFFF_FFF8, 6, -1, 1);  // R10 start while busy, R1 negative stride
    run_op(32'h7000, 32'h4, 1, -1, 0);          // R7 single element
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule